// File: doc/BRIEF.md
# Fuzzy Logic Reference Controller

This block turns a sampled loop error into the modulation reference for a PWM generator. Each time the sample strobe is high it captures the signed error, forms the change in error against the error held from the previous strobe, and scales both by per-sample gain words. It then gives each scaled input a degree of membership in seven triangular sets (NB, NM, NS, ZR, PS, PM, PB). A 7-by-7 rule base combines them, and a weighted average of the output set centres yields a signed reference word.

The pipeline is fully pipelined and fixed in length. A new sample may arrive on every clock, and every sample yields exactly one result a constant number of cycles later, marked by a one-cycle valid pulse. The result word holds its value between pulses, so a downstream modulator can read it at any time.

With the default parameters the set centres of both inputs and of the output lie at multiples of 256: NB=-768, NM=-512, NS=-256, ZR=0, PS=256, PM=512, PB=768. A gain word of 16 is unity.

Top module: `fuzzy_ref_ctrl`

## Requirements
- R1: While `rst` is high and after it is released, `ref_valid` is 0 and `ref_out` is 0 until the first result is due.
- R2: A sample taken on a rising edge with `smp_valid` high raises `ref_valid` for exactly one cycle, 13 rising edges later (QB+3, with QB=$clog2(3*OUT_STEP+1)=10). Samples on consecutive cycles each give their own pulse, and `ref_valid` is 0 in every other cycle.
- R3: The scaled error is (err*e_gain) shifted right arithmetically by 4, then clamped to [-768, 768]. A gain of 0 forces the scaled value to 0.
- R4: The raw change in error is the current error minus the error of the previous sample. The stored error is 0 after reset, so the first sample's change equals its error. The change is scaled and clamped like the error, using `de_gain`.
- R5: Set k (0=NB to 6=PB) has its centre at (k-3)*256 and a triangular membership 256-|v-centre|, floored at 0. Scaled values at or beyond ±768 give full membership (256) in PB or NB.
- R6: Let i be the error set and j the change set, both numbered 0..6, and let s=i+j-6. The output set is NB if s<=-4, NM if s is -3 or -2, NS if s=-1, ZR if s=0, PS if s=1, PM if s is 2 or 3, and PB if s>=4. So (NB,NB)->NB, (PB,PB)->PB, (NB,PB)->ZR, (PB,NB)->ZR.
- R7: A rule's strength is the minimum of its two memberships. `ref_out` is the sum of strength times output centre, divided by the sum of strengths, truncated toward zero.
- R8: `ref_out` changes only in a cycle where `ref_valid` is 1, and otherwise holds the last result.
- R9: Negating the scaled error and the scaled change negates the result.
- R10: Every result lies within [-768, 768].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe; the inputs below are captured on its rising edge |
| err_in | input | W (12) | Signed loop error |
| e_gain | input | GW (8) | Unsigned error gain, 4 fraction bits |
| de_gain | input | GW (8) | Unsigned change-in-error gain, 4 fraction bits |
| ref_valid | output | 1 | One-cycle pulse marking a new result |
| ref_out | output | W (12) | Signed modulation reference, held between pulses |

## Verification
Every sample's result is due exactly 13 rising edges after the edge that captured it. On each capture edge the bench computes the expected value with its own integer model and files it in a ring slot indexed by that due cycle. On every falling edge it compares `ref_valid` and `ref_out` against the slot for the current cycle. In cycles with no result due, it checks that `ref_valid` stays low and that `ref_out` still equals the last result. Directed samples reach the table corners, saturation, zero gains and the stored error after reset, and a random stream with gaps of zero to three cycles exercises back-to-back samples.

// File: rtl/fz_pkg.sv
package fz_pkg;

  localparam int NSETS = 7;

  // Output set for error set ie and change set id (0=NB .. 6=PB),
  // compressed from the diagonal sum of the two set numbers.
  function automatic logic [2:0] rule_of(input logic [2:0] ie, input logic [2:0] id);
    int s;
    s = int'(ie) + int'(id) - 6;
    if (s <= -4)      return 3'd0;
    else if (s <= -2) return 3'd1;
    else if (s == -1) return 3'd2;
    else if (s == 0)  return 3'd3;
    else if (s == 1)  return 3'd4;
    else if (s <= 3)  return 3'd5;
    else              return 3'd6;
  endfunction

endpackage

// File: rtl/fz_scale.sv
module fz_scale #(
  parameter int XW  = 13,
  parameter int GW  = 8,
  parameter int GF  = 4,
  parameter int VW  = 11,
  parameter int LIM = 768
) (
  input  logic signed [XW-1:0] x,
  input  logic        [GW-1:0] g,
  output logic signed [VW-1:0] v
);
  localparam int PW = XW + GW + 1;
  localparam logic signed [PW-1:0] HI = PW'(LIM);
  localparam logic signed [PW-1:0] LO = -HI;

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] shd;

  always_comb begin
    prod = $signed({{(GW+1){x[XW-1]}}, x}) * $signed({{XW{1'b0}}, g});
    shd  = prod >>> GF;
    if (shd > HI)      v = HI[VW-1:0];
    else if (shd < LO) v = LO[VW-1:0];
    else               v = shd[VW-1:0];
  end
endmodule

// File: rtl/fz_fuzzify.sv
module fz_fuzzify #(
  parameter int MSH = 8,
  parameter int VW  = MSH + 3
) (
  input  logic signed [VW-1:0] v,
  output logic        [2:0]    idx,
  output logic        [MSH:0]  mu_lo,
  output logic        [MSH:0]  mu_hi
);
  localparam int S = 1 << MSH;

  logic [VW-1:0]  t;
  logic [2:0]     seg;
  logic [MSH-1:0] frac;

  always_comb begin
    t    = $unsigned(v) + VW'(3 * S);
    seg  = t[VW-1:MSH];
    frac = t[MSH-1:0];
    if (seg >= 3'd6) begin
      idx   = 3'd5;
      mu_lo = '0;
      mu_hi = (MSH+1)'(S);
    end else begin
      idx   = seg;
      mu_lo = (MSH+1)'(S) - {1'b0, frac};
      mu_hi = {1'b0, frac};
    end
  end
endmodule

// File: rtl/fz_rules.sv
module fz_rules
  import fz_pkg::*;
#(
  parameter int MSH      = 8,
  parameter int OUT_STEP = 256,
  parameter int NUMW     = 21,
  parameter int DENW     = 11
) (
  input  logic [2:0]      e_idx,
  input  logic [MSH:0]    e_lo,
  input  logic [MSH:0]    e_hi,
  input  logic [2:0]      d_idx,
  input  logic [MSH:0]    d_lo,
  input  logic [MSH:0]    d_hi,
  output logic            neg,
  output logic [NUMW-1:0] mag,
  output logic [DENW-1:0] den
);
  int acc;
  int dsum;
  int prod;

  always_comb begin
    acc  = 0;
    dsum = 0;
    for (int a = 0; a < 2; a++) begin
      for (int b = 0; b < 2; b++) begin
        int me;
        int md;
        int w;
        int k;
        me = (a == 1) ? int'(e_hi) : int'(e_lo);
        md = (b == 1) ? int'(d_hi) : int'(d_lo);
        w  = (me < md) ? me : md;
        k  = int'(rule_of(3'(e_idx + 3'(a)), 3'(d_idx + 3'(b)))) - 3;
        acc  = acc + w * k;
        dsum = dsum + w;
      end
    end
    prod = acc * OUT_STEP;
    neg  = prod < 0;
    mag  = NUMW'(neg ? -prod : prod);
    den  = DENW'(dsum);
  end
endmodule

// File: rtl/fz_divpipe.sv
module fz_divpipe #(
  parameter int NUMW = 21,
  parameter int DENW = 11,
  parameter int QB   = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_v,
  input  logic            in_neg,
  input  logic [NUMW-1:0] in_mag,
  input  logic [DENW-1:0] in_den,
  output logic            out_v,
  output logic            out_neg,
  output logic [QB-1:0]   out_q
);
  logic            st_v   [0:QB-1];
  logic            st_neg [0:QB-1];
  logic [QB-1:0]   st_q   [0:QB-1];
  logic [NUMW-1:0] st_mag [0:QB-2];
  logic [DENW-1:0] st_den [0:QB-2];

  for (genvar k = 0; k < QB; k++) begin : g_stage
    localparam int B = QB - 1 - k;
    logic            cur_v, cur_neg, ge;
    logic [QB-1:0]   cur_q;
    logic [NUMW-1:0] cur_mag, trial;
    logic [DENW-1:0] cur_den;

    if (k == 0) begin : g_first
      assign cur_v   = in_v;
      assign cur_neg = in_neg;
      assign cur_q   = '0;
      assign cur_mag = in_mag;
      assign cur_den = in_den;
    end else begin : g_next
      assign cur_v   = st_v[k-1];
      assign cur_neg = st_neg[k-1];
      assign cur_q   = st_q[k-1];
      assign cur_mag = st_mag[k-1];
      assign cur_den = st_den[k-1];
    end

    assign trial = NUMW'(cur_den) << B;
    assign ge    = cur_mag >= trial;

    always_ff @(posedge clk) begin
      if (rst) st_v[k] <= 1'b0;
      else     st_v[k] <= cur_v;
      st_neg[k] <= cur_neg;
      st_q[k]   <= cur_q | (ge ? (QB'(1) << B) : '0);
    end

    if (k < QB - 1) begin : g_carry
      always_ff @(posedge clk) begin
        st_mag[k] <= ge ? (cur_mag - trial) : cur_mag;
        st_den[k] <= cur_den;
      end
    end
  end

  assign out_v   = st_v[QB-1];
  assign out_neg = st_neg[QB-1];
  assign out_q   = st_q[QB-1];

  // R7: the weighted average always has a nonzero strength sum
  a_r7_den_nonzero: assert property (@(posedge clk) disable iff (rst)
    in_v |-> (in_den != '0));
endmodule

// File: rtl/fuzzy_ref_ctrl.sv
module fuzzy_ref_ctrl #(
  parameter int W        = 12,
  parameter int GW       = 8,
  parameter int GF       = 4,
  parameter int MSH      = 8,
  parameter int OUT_STEP = 256
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_valid,
  input  logic signed [W-1:0] err_in,
  input  logic        [GW-1:0] e_gain,
  input  logic        [GW-1:0] de_gain,
  output logic                ref_valid,
  output logic signed [W-1:0] ref_out
);
  localparam int S    = 1 << MSH;
  localparam int LIM  = 3 * S;
  localparam int VW   = MSH + 3;
  localparam int DW   = W + 1;
  localparam int QB   = $clog2(3 * OUT_STEP + 1);
  localparam int DENW = MSH + 3;
  localparam int NUMW = DENW + QB;
  localparam int OMAX = 3 * OUT_STEP;

  // stage 1: difference, gain scaling, clamp
  logic signed [W-1:0]  prev_err;
  logic signed [DW-1:0] err_x, prev_x, de_raw;
  logic signed [VW-1:0] e_c, d_c;
  logic signed [VW-1:0] s1_e, s1_d;
  logic                 s1_v;

  assign err_x  = DW'(err_in);
  assign prev_x = DW'(prev_err);
  assign de_raw = err_x - prev_x;

  fz_scale #(.XW(DW), .GW(GW), .GF(GF), .VW(VW), .LIM(LIM)) u_scale_e (
    .x(err_x), .g(e_gain), .v(e_c));
  fz_scale #(.XW(DW), .GW(GW), .GF(GF), .VW(VW), .LIM(LIM)) u_scale_d (
    .x(de_raw), .g(de_gain), .v(d_c));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_err <= '0;
      s1_v     <= 1'b0;
    end else begin
      s1_v <= smp_valid;
      if (smp_valid) prev_err <= err_in;
    end
    s1_e <= e_c;
    s1_d <= d_c;
  end

  // stage 2: fuzzification
  logic [2:0]   fe_idx, fd_idx, s2_e_idx, s2_d_idx;
  logic [MSH:0] fe_lo, fe_hi, fd_lo, fd_hi;
  logic [MSH:0] s2_e_lo, s2_e_hi, s2_d_lo, s2_d_hi;
  logic         s2_v;

  fz_fuzzify #(.MSH(MSH), .VW(VW)) u_fz_e (
    .v(s1_e), .idx(fe_idx), .mu_lo(fe_lo), .mu_hi(fe_hi));
  fz_fuzzify #(.MSH(MSH), .VW(VW)) u_fz_d (
    .v(s1_d), .idx(fd_idx), .mu_lo(fd_lo), .mu_hi(fd_hi));

  always_ff @(posedge clk) begin
    if (rst) s2_v <= 1'b0;
    else     s2_v <= s1_v;
    s2_e_idx <= fe_idx;
    s2_e_lo  <= fe_lo;
    s2_e_hi  <= fe_hi;
    s2_d_idx <= fd_idx;
    s2_d_lo  <= fd_lo;
    s2_d_hi  <= fd_hi;
  end

  // stage 3: rule evaluation and accumulation
  logic            r_neg, s3_neg, s3_v;
  logic [NUMW-1:0] r_mag, s3_mag;
  logic [DENW-1:0] r_den, s3_den;

  fz_rules #(.MSH(MSH), .OUT_STEP(OUT_STEP), .NUMW(NUMW), .DENW(DENW)) u_rules (
    .e_idx(s2_e_idx), .e_lo(s2_e_lo), .e_hi(s2_e_hi),
    .d_idx(s2_d_idx), .d_lo(s2_d_lo), .d_hi(s2_d_hi),
    .neg(r_neg), .mag(r_mag), .den(r_den));

  always_ff @(posedge clk) begin
    if (rst) s3_v <= 1'b0;
    else     s3_v <= s2_v;
    s3_neg <= r_neg;
    s3_mag <= r_mag;
    s3_den <= r_den;
  end

  // defuzzification divide, QB stages
  logic          dv_v, dv_neg;
  logic [QB-1:0] dv_q;
  logic signed [W-1:0] q_s;

  fz_divpipe #(.NUMW(NUMW), .DENW(DENW), .QB(QB)) u_div (
    .clk(clk), .rst(rst), .in_v(s3_v), .in_neg(s3_neg), .in_mag(s3_mag),
    .in_den(s3_den), .out_v(dv_v), .out_neg(dv_neg), .out_q(dv_q));

  assign q_s = W'(dv_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_valid <= 1'b0;
      ref_out   <= '0;
    end else begin
      ref_valid <= dv_v;
      if (dv_v) ref_out <= dv_neg ? -q_s : q_s;
    end
  end

  // R5: adjacent memberships of one input partition unity
  a_r5_partition_e: assert property (@(posedge clk) disable iff (rst)
    s2_v |-> ((MSH+2)'(s2_e_lo) + (MSH+2)'(s2_e_hi) == (MSH+2)'(S)));
  a_r5_partition_d: assert property (@(posedge clk) disable iff (rst)
    s2_v |-> ((MSH+2)'(s2_d_lo) + (MSH+2)'(s2_d_hi) == (MSH+2)'(S)));
  // R10: results stay within the outermost output centres
  a_r10_range: assert property (@(posedge clk) disable iff (rst)
    ref_valid |-> (ref_out <= W'(OMAX) && ref_out >= -W'(OMAX)));
  // R8: the reference moves only with a valid pulse
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (ref_out != $past(ref_out)) |-> ref_valid);
endmodule

// File: tb/fuzzy_ref_ctrl_tb.sv
module fuzzy_ref_ctrl_tb;
  localparam int LAT = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic signed [11:0] err_in = '0;
  logic [7:0] e_gain = 8'd16;
  logic [7:0] de_gain = 8'd16;
  logic ref_valid;
  logic signed [11:0] ref_out;

  always #2.5 clk = ~clk;

  fuzzy_ref_ctrl u_dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .err_in(err_in),
    .e_gain(e_gain), .de_gain(de_gain), .ref_valid(ref_valid), .ref_out(ref_out));

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int prev_m = 0;
  int last_val = 0;
  bit done = 0;
  string cur_tag = "R7";

  bit    exp_v   [64];
  int    exp_val [64];
  string exp_tag [64];

  int tbl [7][7] = '{
    '{0,0,0,1,1,2,3},
    '{0,0,1,1,2,3,4},
    '{0,1,1,2,3,4,5},
    '{1,1,2,3,4,5,5},
    '{1,2,3,4,5,5,6},
    '{2,3,4,5,5,6,6},
    '{3,4,5,5,6,6,6}};

  function automatic int scl(int x, int g);
    int p;
    p = (x * g) >>> 4;
    if (p > 768) p = 768;
    if (p < -768) p = -768;
    return p;
  endfunction

  function automatic int memb(int v, int k);
    int d;
    d = v - (k - 3) * 256;
    if (d < 0) d = -d;
    return (d >= 256) ? 0 : 256 - d;
  endfunction

  function automatic int model(int ev, int dv);
    int num, den;
    num = 0; den = 0;
    for (int i = 0; i < 7; i++)
      for (int j = 0; j < 7; j++) begin
        int a, b, w;
        a = memb(ev, i); b = memb(dv, j);
        w = (a < b) ? a : b;
        num += w * (tbl[i][j] - 3) * 256;
        den += w;
      end
    return num / den;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // reference model: runs on each capture edge
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst) prev_m = 0;
    else if (smp_valid) begin
      int e, ev, dv, slot;
      e  = int'(err_in);
      ev = scl(e, int'(e_gain));
      dv = scl(e - prev_m, int'(de_gain));
      prev_m = e;
      slot = (cyc + LAT) % 64;
      exp_v[slot]   = 1'b1;
      exp_val[slot] = model(ev, dv);
      exp_tag[slot] = cur_tag;
    end
  end

  // comparison on every falling edge
  always @(negedge clk) begin
    if (rst) begin
      check(ref_valid == 1'b0, "R1", "valid in reset", int'(ref_valid), 0);
      check(ref_out == 0, "R1", "output in reset", int'(ref_out), 0);
    end else if (!done) begin
      int s;
      s = cyc % 64;
      if (exp_v[s]) begin
        check(ref_valid == 1'b1, "R2", "valid pulse due", int'(ref_valid), 1);
        check(int'(ref_out) == exp_val[s], exp_tag[s], "result", int'(ref_out), exp_val[s]);
        check(ref_out <= 768 && ref_out >= -768, "R10", "range", int'(ref_out), 768);
        last_val = exp_val[s];
        exp_v[s] = 1'b0;
      end else begin
        check(ref_valid == 1'b0, "R2", "no pulse due", int'(ref_valid), 0);
        check(int'(ref_out) == last_val, "R8", "held output", int'(ref_out), last_val);
      end
    end
  end

  task automatic smp(int e, int ge, int gd, string tag);
    @(negedge clk);
    smp_valid = 1'b1;
    err_in    = 12'(e);
    e_gain    = 8'(ge);
    de_gain   = 8'(gd);
    cur_tag   = tag;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_valid = 1'b0;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(3);
    // R1: nothing appears after reset without a sample
    check(ref_valid == 1'b0 && ref_out == 0, "R1", "after release", int'(ref_out), 0);
    // R4: first change equals the error, then zero change
    smp(300, 16, 16, "R4"); idle(2);
    smp(300, 16, 16, "R4"); idle(2);
    // R6: table corners
    smp(-800, 16, 16, "R6"); idle(1);
    smp(800, 16, 16, "R6"); idle(1);
    smp(-1600, 16, 16, "R6");
    smp(-800, 16, 16, "R6");
    smp(1600, 16, 16, "R6");
    smp(800, 16, 16, "R6"); idle(2);
    // R3: zero and half gain
    smp(1000, 0, 0, "R3");
    smp(600, 8, 16, "R3"); idle(1);
    // R5: saturation and midpoint between sets
    smp(2047, 16, 0, "R5");
    smp(-2048, 16, 0, "R5");
    smp(128, 16, 0, "R5"); idle(1);
    // R9: mirrored inputs
    smp(0, 16, 16, "R9"); smp(200, 16, 16, "R9"); idle(1);
    smp(0, 16, 16, "R9"); smp(-200, 16, 16, "R9"); idle(1);
    // R7: random stream, back-to-back and gapped
    for (int n = 0; n < 400; n++) begin
      int gap;
      smp(int'($urandom_range(4095)) - 2048,
          ($urandom_range(3) == 0) ? 16 : int'($urandom_range(255)),
          ($urandom_range(3) == 0) ? 16 : int'($urandom_range(255)), "R7");
      gap = int'($urandom_range(3));
      if (gap > 0) idle(gap);
    end
    idle(LAT + 6);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule